// File: doc/BRIEF.md
# Integer ALU instruction decoder with microcode table

This combinational block sits in the decode stage of a small 32-bit integer core. It looks at three fields of an instruction: the 7-bit major opcode, the 3-bit minor function field and the 7-bit extended function field. From them it recognises eight register-register and register-immediate ALU operations: add, sub, and, or, slt, addi, slti and andi.

Recognition happens in three steps. First, one comparator per operation raises a match line. Second, a highest-index-wins priority encoder turns the match lines into a 3-bit table address. Third, that address selects a word from a fixed eight-entry microcode table. The 8-bit word is split into a register write enable, an operand-B source select, a 2-bit immediate-format select and a 4-bit ALU operation code. A valid flag tells the pipeline whether any operation was recognised. When nothing is recognised, the register write enable is held low, so an unknown instruction can never change architectural state.

Top module: `ucode_decoder`

## Requirements
- R1: Each supported operation raises exactly one bit of `match_o`, at its table address: add 0, sub 1, and 2, or 3, slt 4, addi 5, slti 6, andi 7. Every other field combination leaves `match_o` at zero.
- R2: Register-register forms match on major opcode 0110011. Their minor function codes are 000 for add and sub, 111 for and, 110 for or and 010 for slt. Their extended function field must be 0100000 for sub and 0000000 for the other four.
- R3: Register-immediate forms match on major opcode 0010011 with minor function code 000 (addi), 010 (slti) or 111 (andi). The extended function field has no effect on these three.
- R4: `ctrl_word_o` for a recognised operation is, in hex: add 82, sub 86, and 80, or 81, slt 87, addi C2, slti C7, andi C0.
- R5: Bit layout of `ctrl_word_o`: bit 7 drives `reg_write_o`, bit 6 drives `alu_src_o` (1 selects the immediate), bits 5:4 drive `imm_sel_o` and bits 3:0 drive `alu_op_o`. The ALU codes are AND 0000, OR 0001, add 0010, sub 0110 and set-less-than 0111.
- R6: `valid_o` is 1 exactly when some operation is recognised. `hit_idx_o` then carries its table address. The priority rule is that the highest active match index wins.
- R7: With no match, `valid_o` is 0, `hit_idx_o` is 000, `reg_write_o` is 0 and `ctrl_word_o` is 02 hex. This is the address-0 entry with its write enable cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 7 | Major opcode field of the instruction |
| funct3_i | input | 3 | Minor function field |
| funct7_i | input | 7 | Extended function field |
| match_o | output | 8 | One match line per supported operation |
| valid_o | output | 1 | Some operation recognised |
| hit_idx_o | output | 3 | Microcode table address |
| ctrl_word_o | output | 8 | Full control word |
| reg_write_o | output | 1 | Register file write enable |
| alu_src_o | output | 1 | Operand B source, 1 = immediate |
| imm_sel_o | output | 2 | Immediate format select |
| alu_op_o | output | 4 | ALU operation code |

## Verification
Immediate assertions check several properties on every evaluation. The match lines are never more than one-hot. The encoder's address always points at an active line, with no active line above it. `valid_o` agrees with the match lines. An unrecognised instruction never asserts the write enable and always yields address zero. The assertions cannot tell whether the right bit patterns map to the right operation or whether each table entry holds the right word. The bench covers these by sweeping every major opcode and minor function code against a set of extended function values and comparing each output with values it derives from the encoding rules.

// File: rtl/ucode_dec_pkg.sv
package ucode_dec_pkg;

    localparam int NUM_OPS   = 8;
    localparam int IDX_W     = $clog2(NUM_OPS);
    localparam int OPC_W     = 7;
    localparam int F3_W      = 3;
    localparam int F7_W      = 7;
    localparam int CW_W      = 8;

    localparam logic [OPC_W-1:0] OPC_REG = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_IMM = 7'b0010011;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_op_e;

    typedef struct packed {
        logic            reg_write;
        logic            alu_src;
        logic [1:0]      imm_sel;
        alu_op_e         alu_op;
    } ctrl_word_t;

    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        logic [F3_W-1:0]  funct3;
        logic [F7_W-1:0]  funct7;
        logic             chk_f7;
    } pattern_t;

    // Encoding pattern for the operation held at table address idx
    function automatic pattern_t op_pattern(input int idx);
        pattern_t p;
        p = '{OPC_REG, 3'b000, 7'b0000000, 1'b1};
        case (idx)
            0: p = '{OPC_REG, 3'b000, 7'b0000000, 1'b1};
            1: p = '{OPC_REG, 3'b000, 7'b0100000, 1'b1};
            2: p = '{OPC_REG, 3'b111, 7'b0000000, 1'b1};
            3: p = '{OPC_REG, 3'b110, 7'b0000000, 1'b1};
            4: p = '{OPC_REG, 3'b010, 7'b0000000, 1'b1};
            5: p = '{OPC_IMM, 3'b000, 7'b0000000, 1'b0};
            6: p = '{OPC_IMM, 3'b010, 7'b0000000, 1'b0};
            7: p = '{OPC_IMM, 3'b111, 7'b0000000, 1'b0};
            default: p = '{OPC_REG, 3'b000, 7'b0000000, 1'b1};
        endcase
        return p;
    endfunction

    // Microcode word stored at table address idx
    function automatic ctrl_word_t ucode_entry(input logic [IDX_W-1:0] idx);
        ctrl_word_t w;
        case (idx)
            3'd0: w = '{1'b1, 1'b0, 2'b00, ALU_ADD};
            3'd1: w = '{1'b1, 1'b0, 2'b00, ALU_SUB};
            3'd2: w = '{1'b1, 1'b0, 2'b00, ALU_AND};
            3'd3: w = '{1'b1, 1'b0, 2'b00, ALU_OR};
            3'd4: w = '{1'b1, 1'b0, 2'b00, ALU_SLT};
            3'd5: w = '{1'b1, 1'b1, 2'b00, ALU_ADD};
            3'd6: w = '{1'b1, 1'b1, 2'b00, ALU_SLT};
            default: w = '{1'b1, 1'b1, 2'b00, ALU_AND};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/op_matcher.sv
module op_matcher
    import ucode_dec_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode_i,
    input  logic [F3_W-1:0]    funct3_i,
    input  logic [F7_W-1:0]    funct7_i,
    output logic [NUM_OPS-1:0] match_o
);

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cmp
        localparam pattern_t PAT = op_pattern(g);
        assign match_o[g] = (opcode_i == PAT.opcode) &&
                            (funct3_i == PAT.funct3) &&
                            (!PAT.chk_f7 || (funct7_i == PAT.funct7));
    end

    always_comb begin
        // R1
        match_onehot_chk: assert ($onehot0(match_o));
        // R2
        match_opcode_chk: assert (match_o == '0 || opcode_i == OPC_REG || opcode_i == OPC_IMM);
    end

endmodule

// File: rtl/prio_encoder.sv
module prio_encoder #(
    parameter int N     = 8,
    parameter int OUT_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic [OUT_W-1:0] idx_o,
    output logic             any_o
);

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) idx_o = OUT_W'(i);
        end
    end

    assign any_o = |req_i;

    always_comb begin
        // R6
        prio_points_active_chk: assert (!any_o || req_i[idx_o]);
        // R6
        prio_none_above_chk: assert (((req_i >> idx_o) >> 1) == '0);
    end

endmodule

// File: rtl/ucode_rom.sv
module ucode_rom
    import ucode_dec_pkg::*;
(
    input  logic [IDX_W-1:0] addr_i,
    output ctrl_word_t       word_o
);

    assign word_o = ucode_entry(addr_i);

endmodule

// File: rtl/ucode_decoder.sv
module ucode_decoder
    import ucode_dec_pkg::*;
(
    input  logic [6:0] opcode_i,
    input  logic [2:0] funct3_i,
    input  logic [6:0] funct7_i,
    output logic [7:0] match_o,
    output logic       valid_o,
    output logic [2:0] hit_idx_o,
    output logic [7:0] ctrl_word_o,
    output logic       reg_write_o,
    output logic       alu_src_o,
    output logic [1:0] imm_sel_o,
    output logic [3:0] alu_op_o
);

    logic [NUM_OPS-1:0] match;
    logic [IDX_W-1:0]   idx;
    logic               any;
    ctrl_word_t         rom_word;
    ctrl_word_t         word;

    op_matcher u_match (
        .opcode_i (opcode_i),
        .funct3_i (funct3_i),
        .funct7_i (funct7_i),
        .match_o  (match)
    );

    prio_encoder #(.N(NUM_OPS)) u_prio (
        .req_i (match),
        .idx_o (idx),
        .any_o (any)
    );

    ucode_rom u_rom (
        .addr_i (idx),
        .word_o (rom_word)
    );

    always_comb begin
        word           = rom_word;
        word.reg_write = rom_word.reg_write & any;
    end

    assign match_o     = match;
    assign valid_o     = any;
    assign hit_idx_o   = idx;
    assign ctrl_word_o = word;
    assign reg_write_o = word.reg_write;
    assign alu_src_o   = word.alu_src;
    assign imm_sel_o   = word.imm_sel;
    assign alu_op_o    = word.alu_op;

    always_comb begin
        // R7
        no_write_unknown_chk: assert (valid_o || !reg_write_o);
        // R7
        idle_index_chk: assert (valid_o || hit_idx_o == '0);
        // R6
        valid_match_chk: assert (valid_o == (match_o != '0));
    end

endmodule

// File: tb/ucode_decoder_bench.sv
module ucode_decoder_bench;

    logic       clk = 1'b0;
    logic [6:0] opcode;
    logic [2:0] funct3;
    logic [6:0] funct7;
    logic [7:0] match;
    logic       valid;
    logic [2:0] hit_idx;
    logic [7:0] cword;
    logic       reg_write;
    logic       alu_src;
    logic [1:0] imm_sel;
    logic [3:0] alu_op;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ucode_decoder u_ucode_decoder (
        .opcode_i    (opcode),
        .funct3_i    (funct3),
        .funct7_i    (funct7),
        .match_o     (match),
        .valid_o     (valid),
        .hit_idx_o   (hit_idx),
        .ctrl_word_o (cword),
        .reg_write_o (reg_write),
        .alu_src_o   (alu_src),
        .imm_sel_o   (imm_sel),
        .alu_op_o    (alu_op)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%b f3=%b f7=%b actual=%h expected=%h",
                     req, opcode, funct3, funct7, act, exp);
        end
    endtask

    // Expected table address from the encoding rules; -1 when unrecognised
    function automatic int exp_index(input logic [6:0] o, input logic [2:0] f3, input logic [6:0] f7);
        if (o == 7'b0110011) begin
            if (f3 == 3'b000 && f7 == 7'b0000000) return 0;
            if (f3 == 3'b000 && f7 == 7'b0100000) return 1;
            if (f3 == 3'b111 && f7 == 7'b0000000) return 2;
            if (f3 == 3'b110 && f7 == 7'b0000000) return 3;
            if (f3 == 3'b010 && f7 == 7'b0000000) return 4;
        end else if (o == 7'b0010011) begin
            if (f3 == 3'b000) return 5;
            if (f3 == 3'b010) return 6;
            if (f3 == 3'b111) return 7;
        end
        return -1;
    endfunction

    function automatic logic [7:0] exp_word(input int k);
        case (k)
            0: return 8'h82;
            1: return 8'h86;
            2: return 8'h80;
            3: return 8'h81;
            4: return 8'h87;
            5: return 8'hC2;
            6: return 8'hC7;
            7: return 8'hC0;
            default: return 8'h02;
        endcase
    endfunction

    task automatic apply_and_check(input logic [6:0] o, input logic [2:0] f3, input logic [6:0] f7);
        int k;
        logic [7:0] w;
        @(negedge clk);
        opcode = o; funct3 = f3; funct7 = f7;
        #1;
        k = exp_index(o, f3, f7);
        w = exp_word(k);
        if (k >= 0) begin
            check((o == 7'b0010011) ? "R3" : "R2", match, 8'(1) << k);
            check("R1", {7'b0, $onehot(match)}, 8'h01);
            check("R6", {7'b0, valid}, 8'h01);
            check("R6", {5'b0, hit_idx}, 8'(k));
            check("R4", cword, w);
        end else begin
            check("R1", match, 8'h00);
            check("R7", {7'b0, valid}, 8'h00);
            check("R7", {5'b0, hit_idx}, 8'h00);
            check("R7", cword, 8'h02);
        end
        check("R5", {reg_write, alu_src, imm_sel, alu_op}, w);
    endtask

    initial begin
        opcode = '0; funct3 = '0; funct7 = '0;
        @(negedge clk);
        #1;
        // R7: all-zero fields are not a supported operation
        check("R7", {7'b0, reg_write}, 8'h00);
        check("R7", {7'b0, valid}, 8'h00);

        // R2, R3: extended field ignored for immediate forms
        apply_and_check(7'b0010011, 3'b000, 7'b1111111);
        apply_and_check(7'b0010011, 3'b111, 7'b0100000);
        apply_and_check(7'b0110011, 3'b000, 7'b0000001);
        apply_and_check(7'b0110011, 3'b111, 7'b0100000);

        for (int o = 0; o < 128; o++) begin
            for (int f3 = 0; f3 < 8; f3++) begin
                for (int s = 0; s < 5; s++) begin
                    logic [6:0] f7;
                    case (s)
                        0: f7 = 7'b0000000;
                        1: f7 = 7'b0100000;
                        2: f7 = 7'b0000001;
                        3: f7 = 7'b1111111;
                        default: f7 = 7'b1000000;
                    endcase
                    apply_and_check(7'(o), 3'(f3), f7);
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule